// File: doc/BRIEF.md
# Pipelined 8-bit Minifloat Adder

This block adds two 8-bit floating-point numbers. Each number has one sign bit, four exponent bits and three fraction bits. Operands enter with a valid strobe. The rounded sum leaves exactly two clock cycles later with its own valid strobe and three flags: overflow, invalid and inexact.

The arithmetic follows the IEEE 754 rules, scaled down to this small format. Exponents are biased and the bias defaults to 7. Subnormals give gradual underflow, zero is signed, infinity is signed, and NaN is recognised. The first pipeline stage:
- decodes both operands,
- orders them by magnitude,
- aligns the smaller one with guard, round and sticky bits,
- adds or subtracts the significands.

The second stage normalises the result, rounds it to nearest with ties to even, and packs the output byte. The largest finite magnitude is 240, so large sums reach infinity quickly. The overflow path is therefore an everyday case, not a rare one.

Each cycle with `inValid` high starts one independent addition. Any pattern of back-to-back operands and idle gaps is accepted.

Top module: `minifloat_adder`

## Requirements
- R1: Encoding. Bit 7 is the sign, bits 6:3 are the biased exponent e and bits 2:0 are the fraction f. When e is nonzero, the value is 1.f × 2^(e−7). A finite sum that the format can represent exactly comes out exactly: for example, 0x38 (1.0) + 0x38 gives 0x40 (2.0), with no flags.
- R2: `outValid` is `inValid` delayed by exactly two clock cycles, for any pattern of gaps. A synchronous active-high `rst` clears both valid stages, so `outValid` is 0 on the cycle after a reset edge.
- R3: If either operand is NaN (e = 15 with f ≠ 0), the result is the canonical NaN 0x7C and all three flags are 0. No other NaN pattern ever appears at `sumOut`.
- R4: Adding two infinities of opposite sign (0x78 and 0xF8) gives 0x7C with `invFlag` = 1.
- R5: An infinity (e = 15, f = 0) plus any finite value, or plus an infinity of the same sign, returns that infinity unchanged, with all flags 0.
- R6: If the rounded magnitude of a finite sum would exceed 240 (0x77), the result is infinity carrying the sign of the sum (0x78 or 0xF8). Both `ovfFlag` and `inxFlag` are set.
- R7: A sum that cannot be represented exactly is rounded to the nearest value, with ties going to an even fraction, and `inxFlag` is set. Example: 1.0 + 0.0625 gives 0x38. Sums between 240 and 248 round down to 240 without overflow.
- R8: An exactly cancelling sum of finite operands with opposite signs gives +0 (0x00). (−0) + (−0) gives −0 (0x80).
- R9: When e = 0 the number is subnormal, with value 0.f × 2^−6. Sums among subnormals are exact, and they carry across into the smallest normal: 0x07 + 0x01 gives 0x08.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Operands on opA/opB are to be added this cycle |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| outValid | output | 1 | sumOut and flags carry a result this cycle |
| sumOut | output | 8 | Rounded sum |
| ovfFlag | output | 1 | Finite sum rounded past the largest finite value |
| invFlag | output | 1 | Opposite infinities were added |
| inxFlag | output | 1 | Result differs from the exact sum |

## Verification
The bound checker watches the following properties on every cycle:
- the two-cycle valid delay in both directions;
- that every NaN output is the canonical byte, and that any NaN operand leads to that byte with clear flags;
- that opposite infinities produce NaN with the invalid flag;
- that an infinity passes through a finite addend unchanged;
- that an overflow output is always a signed infinity with inexact set;
- the sign of a sum of two zeros.

The numerical content of finite sums cannot be expressed as a small property. This covers correct rounding on exact ties, the rule that cancellation gives positive zero, and the carry of subnormals into normals. Only the bench's reference model shows these. It sweeps every operand pair, runs directed corner cases, and applies a mid-stream reset.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  // Load strobes handed from the valid control to the datapath stages.
  typedef struct packed {
    logic ldAlign;  // capture operands into the align/add stage
    logic ldRound;  // capture the normalised, rounded result
  } mfaStrobe_t;
endpackage

// File: rtl/mfa_ctrl.sv
module mfa_ctrl
  import mfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output mfaStrobe_t strobe,
  output logic       outValid
);
  logic alignValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      alignValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      alignValid <= inValid;
      outValid   <= alignValid;
    end
  end

  assign strobe.ldAlign = inValid;
  assign strobe.ldRound = alignValid;
endmodule

// File: rtl/mfa_datapath.sv
module mfa_datapath
  import mfa_pkg::*;
#(
  parameter  int EXP_W = 4,
  parameter  int MAN_W = 3,
  localparam int W     = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  mfaStrobe_t   strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut,
  output logic         ovfFlag,
  output logic         invFlag,
  output logic         inxFlag
);
  localparam int SIG_W   = MAN_W + 1;   // significand with hidden bit
  localparam int EXT_W   = SIG_W + 3;   // plus guard, round, sticky
  localparam int SUM_W   = EXT_W + 1;   // plus carry
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  // ---------------- stage 1: unpack, order, align, add ----------------
  logic               sgnA, sgnB;
  logic [EXP_W-1:0]   expA, expB;
  logic [MAN_W-1:0]   manA, manB;
  assign {sgnA, expA, manA} = opA;
  assign {sgnB, expB, manB} = opB;

  logic nanA, nanB, infA, infB;
  assign nanA = (expA == EXP_W'(EXP_MAX)) && (manA != '0);
  assign nanB = (expB == EXP_W'(EXP_MAX)) && (manB != '0);
  assign infA = (expA == EXP_W'(EXP_MAX)) && (manA == '0);
  assign infB = (expB == EXP_W'(EXP_MAX)) && (manB == '0);

  logic               swap, bigSign, smallSign;
  logic [EXP_W-1:0]   bigExp, smallExp, bigEff, smallEff;
  logic [MAN_W-1:0]   bigMan, smallMan;
  logic [EXT_W-1:0]   bigExt, smallExt, smallAligned, shifted;
  logic               lostBits, effSub;
  logic [SUM_W-1:0]   sumRaw;
  int                 shiftAmt;

  always_comb begin
    swap      = {expB, manB} > {expA, manA};
    bigSign   = swap ? sgnB : sgnA;
    smallSign = swap ? sgnA : sgnB;
    bigExp    = swap ? expB : expA;
    smallExp  = swap ? expA : expB;
    bigMan    = swap ? manB : manA;
    smallMan  = swap ? manA : manB;
    // subnormals share the exponent of the smallest normal
    bigEff    = (bigExp == '0)   ? EXP_W'(1) : bigExp;
    smallEff  = (smallExp == '0) ? EXP_W'(1) : smallExp;
    bigExt    = {(bigExp != '0),   bigMan,   3'b000};
    smallExt  = {(smallExp != '0), smallMan, 3'b000};
    shiftAmt  = int'(bigEff) - int'(smallEff);
    lostBits  = 1'b0;
    if (shiftAmt >= EXT_W) begin
      shifted  = '0;
      lostBits = |smallExt;
    end else begin
      for (int i = 0; i < EXT_W; i++) begin
        if (i < shiftAmt) lostBits = lostBits | smallExt[i];
      end
      shifted = smallExt >> shiftAmt;
    end
    smallAligned = {shifted[EXT_W-1:1], shifted[0] | lostBits};
    effSub       = bigSign ^ smallSign;
    sumRaw       = effSub ? ({1'b0, bigExt} - {1'b0, smallAligned})
                          : ({1'b0, bigExt} + {1'b0, smallAligned});
  end

  logic               anyNan, infClash;
  assign anyNan   = nanA | nanB;
  assign infClash = infA & infB & (sgnA ^ sgnB);

  logic [SUM_W-1:0] alSum;
  logic [EXP_W-1:0] alExp;
  logic             alSign, alNan, alInv, alInf, alInfSign;

  always_ff @(posedge clk) begin
    if (strobe.ldAlign) begin
      alSum     <= sumRaw;
      alExp     <= bigEff;
      // exact cancellation rounds to +0; equal-signed zeros keep their sign
      alSign    <= (effSub && sumRaw == '0) ? 1'b0 : bigSign;
      alNan     <= anyNan | infClash;
      alInv     <= infClash & ~anyNan;
      alInf     <= (infA | infB) & ~anyNan & ~infClash;
      alInfSign <= infA ? sgnA : sgnB;
    end
  end

  // ---------------- stage 2: normalise, round, pack ----------------
  logic [EXT_W-1:0] normSig;
  logic [SIG_W-1:0] mant;
  logic [SIG_W:0]   rounded;
  logic [MAN_W-1:0] fracOut;
  logic             grd, stk, roundUp, overflow;
  logic [W-1:0]     nxtSum;
  logic [2:0]       nxtFlags;
  int               lead, shAmt, expI;

  always_comb begin
    lead = -1;
    for (int i = 0; i < EXT_W; i++) begin
      if (alSum[i]) lead = i;
    end
    expI  = int'(alExp);
    shAmt = 0;
    if (alSum[SUM_W-1]) begin
      normSig = {alSum[SUM_W-1:2], alSum[1] | alSum[0]};
      expI    = expI + 1;
    end else begin
      shAmt = EXT_W - 1 - lead;
      if (shAmt > expI - 1) shAmt = expI - 1;
      normSig = alSum[EXT_W-1:0] << shAmt;
      expI    = expI - shAmt;
    end
    mant    = normSig[EXT_W-1:3];
    grd     = normSig[2];
    stk     = normSig[1] | normSig[0];
    roundUp = grd & (stk | mant[0]);
    rounded = {1'b0, mant} + {{SIG_W{1'b0}}, roundUp};
    if (rounded[SIG_W]) begin
      expI    = expI + 1;
      fracOut = '0;
    end else begin
      fracOut = rounded[MAN_W-1:0];
      if (!rounded[MAN_W]) expI = 0;   // still subnormal after rounding
    end
    overflow = (expI >= EXP_MAX);

    if (alNan) begin
      nxtSum   = CANON_NAN;
      nxtFlags = {1'b0, alInv, 1'b0};
    end else if (alInf) begin
      nxtSum   = {alInfSign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      nxtFlags = 3'b000;
    end else if (overflow) begin
      nxtSum   = {alSign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      nxtFlags = 3'b101;
    end else begin
      nxtSum   = {alSign, EXP_W'(expI), fracOut};
      nxtFlags = {2'b00, grd | stk};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.ldRound) begin
      sumOut                      <= nxtSum;
      {ovfFlag, invFlag, inxFlag} <= nxtFlags;
    end
  end
endmodule

// File: rtl/minifloat_adder.sv
module minifloat_adder
  import mfa_pkg::*;
#(
  parameter  int EXP_W = 4,
  parameter  int MAN_W = 3,
  parameter  int BIAS  = 7,
  localparam int W     = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         outValid,
  output logic [W-1:0] sumOut,
  output logic         ovfFlag,
  output logic         invFlag,
  output logic         inxFlag
);
  // Addition depends only on exponent differences, so the bias needs
  // only to lie within the usable exponent range.
  if (BIAS < 1 || BIAS > (1 << EXP_W) - 2) begin : g_bias_range
    $error("minifloat_adder: BIAS outside exponent range");
  end

  mfaStrobe_t strobe;

  mfa_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mfa_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .sumOut  (sumOut),
    .ovfFlag (ovfFlag),
    .invFlag (invFlag),
    .inxFlag (inxFlag)
  );
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter  int EXP_W = 4,
  parameter  int MAN_W = 3,
  localparam int W     = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         outValid,
  input logic [W-1:0] sumOut,
  input logic         ovfFlag,
  input logic         invFlag,
  input logic         inxFlag
);
  localparam logic [EXP_W-1:0] ONES = {EXP_W{1'b1}};
  localparam logic [W-1:0] CANON_NAN =
    {1'b0, ONES, 1'b1, {(MAN_W-1){1'b0}}};

  logic nanA, nanB, infA, infB, zeroA, zeroB, outNan;
  assign nanA   = (opA[W-2:MAN_W] == ONES) && (opA[MAN_W-1:0] != '0);
  assign nanB   = (opB[W-2:MAN_W] == ONES) && (opB[MAN_W-1:0] != '0);
  assign infA   = (opA[W-2:MAN_W] == ONES) && (opA[MAN_W-1:0] == '0);
  assign infB   = (opB[W-2:MAN_W] == ONES) && (opB[MAN_W-1:0] == '0);
  assign zeroA  = (opA[W-2:0] == '0);
  assign zeroB  = (opB[W-2:0] == '0);
  assign outNan = (sumOut[W-2:MAN_W] == ONES) && (sumOut[MAN_W-1:0] != '0);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##2 outValid);
  p_bubble_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##2 !outValid);
  p_nan_in_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && (nanA || nanB)) |-> ##2
      (sumOut == CANON_NAN && !ovfFlag && !invFlag && !inxFlag));
  p_nan_canon_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && outNan) |-> (sumOut == CANON_NAN));
  p_inf_clash_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && infA && infB && (opA[W-1] != opB[W-1])) |-> ##2
      (sumOut == CANON_NAN && invFlag));
  p_invalid_nan_r4: assert property (@(posedge clk) disable iff (rst)
    (outValid && invFlag) |-> (sumOut == CANON_NAN));
  p_inf_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && infA && !nanB && !infB) |-> ##2
      (sumOut == $past(opA, 2) && !ovfFlag && !invFlag && !inxFlag));
  p_ovf_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && ovfFlag) |->
      (sumOut[W-2:MAN_W] == ONES && sumOut[MAN_W-1:0] == '0 && inxFlag));
  p_zero_sign_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && zeroA && zeroB) |-> ##2
      (sumOut == {$past(opA[W-1] & opB[W-1], 2), {(W-1){1'b0}}}));
endmodule

bind minifloat_adder mfa_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .sumOut   (sumOut),
  .ovfFlag  (ovfFlag),
  .invFlag  (invFlag),
  .inxFlag  (inxFlag)
);

// File: tb/tb_minifloat_adder.sv
`timescale 1ns/1ps
module tb_minifloat_adder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] opA = '0, opB = '0;
  logic       outValid, ovfFlag, invFlag, inxFlag;
  logic [7:0] sumOut;

  minifloat_adder dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .sumOut(sumOut),
    .ovfFlag(ovfFlag), .invFlag(invFlag), .inxFlag(inxFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    bit         v;
    logic [7:0] r;
    logic [2:0] f;   // {ovf, inv, inx}
    string      tag;
  } expEntry_t;

  expEntry_t q[$];
  int nCmp = 0, nFail = 0, cycles = 0;

  // value in units of the smallest subnormal (2^-9)
  function automatic int toUnits(logic [7:0] v);
    int e = int'(v[6:3]);
    int m = int'(v[2:0]);
    int mag = (e == 0) ? m : ((8 + m) << (e - 1));
    return v[7] ? -mag : mag;
  endfunction

  // behavioural reference: exact integer sum, then round to nearest even
  function automatic logic [10:0] refAdd(logic [7:0] a, logic [7:0] b);
    bit nanA = (a[6:3] == 4'hF) && (a[2:0] != 0);
    bit nanB = (b[6:3] == 4'hF) && (b[2:0] != 0);
    bit infA = (a[6:3] == 4'hF) && (a[2:0] == 0);
    bit infB = (b[6:3] == 4'hF) && (b[2:0] == 0);
    int s, mag, q1, quo, rem, rnd, code;
    bit sg, up;
    if (nanA || nanB) return {8'h7C, 3'b000};
    if (infA && infB && a[7] != b[7]) return {8'h7C, 3'b010};
    if (infA) return {a, 3'b000};
    if (infB) return {b, 3'b000};
    s   = toUnits(a) + toUnits(b);
    sg  = (s < 0);
    mag = sg ? -s : s;
    if (mag == 0) return {((a[7] & b[7]) ? 8'h80 : 8'h00), 3'b000};
    if (mag >= (1 << 17)) return {sg, 7'h78, 3'b101};
    q1 = 1;
    for (int e = 2; e <= 14; e++) if (mag >= (8 << (e - 1))) q1 = 1 << (e - 1);
    quo = mag / q1;
    rem = mag % q1;
    up  = (2 * rem > q1) || (2 * rem == q1 && (quo % 2) == 1);
    rnd = (quo + int'(up)) * q1;
    if (rnd >= (1 << 17)) return {sg, 7'h78, 3'b101};
    if (rnd < 16) code = rnd;
    else begin
      code = 0;
      for (int e = 1; e <= 14; e++)
        if (rnd >= (8 << (e - 1))) code = e * 8 + (rnd >> (e - 1)) - 8;
    end
    return {sg, code[6:0], 2'b00, (rem != 0)};
  endfunction

  task automatic checkOut();
    expEntry_t e;
    if (q.size() == 2) begin
      e = q.pop_front();
      nCmp++;
      if (outValid !== e.v) begin
        nFail++;
        $display("FAIL %s: outValid=%0b expected %0b", e.tag, outValid, e.v);
      end else if (e.v && ({sumOut, ovfFlag, invFlag, inxFlag} !== {e.r, e.f})) begin
        nFail++;
        $display("FAIL %s: sum=%h flags=%b expected sum=%h flags=%b",
                 e.tag, sumOut, {ovfFlag, invFlag, inxFlag}, e.r, e.f);
      end
    end
  endtask

  task automatic step(input bit v, input logic [7:0] a, input logic [7:0] b,
                      input string tag);
    expEntry_t e;
    @(negedge clk);
    checkOut();
    inValid = v; opA = a; opB = b;
    e.v = v; {e.r, e.f} = refAdd(a, b); e.tag = tag;
    q.push_back(e);
  endtask

  // mid-stream reset: everything in flight is dropped (R2)
  task automatic pulseReset();
    expEntry_t e;
    @(negedge clk);
    checkOut();
    rst = 1'b1; inValid = 1'b0;
    e.v = 1'b0; e.r = '0; e.f = '0; e.tag = "R2";
    q.push_back(e);
    foreach (q[k]) q[k].v = 1'b0;
    @(negedge clk);
    checkOut();
    rst = 1'b0;
    q.push_back(e);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nFail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nFail++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nCmp++;  // R2 reset state
    if (outValid !== 1'b0) begin
      nFail++;
      $display("FAIL R2: outValid=%0b after reset expected 0", outValid);
    end
    // R1 exact normal sums
    step(1, 8'h38, 8'h38, "R1");
    step(1, 8'h3C, 8'h44, "R1");
    step(1, 8'hC4, 8'h38, "R1");
    // R9 subnormal behaviour
    step(1, 8'h01, 8'h01, "R9");
    step(1, 8'h07, 8'h01, "R9");
    step(1, 8'h08, 8'h81, "R9");
    step(0, 8'h00, 8'h00, "R2");
    // R3 NaN operands
    step(1, 8'h79, 8'h38, "R3");
    step(1, 8'hFF, 8'h78, "R3");
    // R4 opposite infinities
    step(1, 8'h78, 8'hF8, "R4");
    // R5 infinity passes through
    step(1, 8'h78, 8'h77, "R5");
    step(1, 8'hF8, 8'h38, "R5");
    step(1, 8'h78, 8'h78, "R5");
    // R6 overflow
    step(1, 8'h77, 8'h77, "R6");
    step(1, 8'hF7, 8'hF0, "R6");
    step(1, 8'h77, 8'h50, "R6");
    // R7 rounding, ties to even, near the top of the range
    step(1, 8'h77, 8'h30, "R7");
    step(1, 8'h38, 8'h08, "R7");
    step(1, 8'h38, 8'h1C, "R7");
    step(1, 8'h38, 8'h18, "R7");
    step(1, 8'h39, 8'h18, "R7");
    // R8 signed zeros and cancellation
    step(1, 8'h3A, 8'hBA, "R8");
    step(1, 8'h80, 8'h80, "R8");
    step(1, 8'h00, 8'h80, "R8");
    step(1, 8'h80, 8'h00, "R8");
    step(1, 8'h39, 8'hB8, "R1");
    // R2 reset while results are in flight
    step(1, 8'h38, 8'h38, "R2");
    step(1, 8'h40, 8'h40, "R2");
    pulseReset();
    step(1, 8'h48, 8'h38, "R2");
    // R1 full sweep of every operand pair, back to back
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(1, 8'(a), 8'(b), "R1");
    // R2 random gaps
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, 8'($urandom), 8'($urandom), "R2");
    step(0, 8'h00, 8'h00, "R2");
    step(0, 8'h00, 8'h00, "R2");
    step(0, 8'h00, 8'h00, "R2");
    finishRun();
  end
endmodule